// File: doc/BRIEF.md
# Sequential Multi-Level Page Table Walker

This block translates one virtual address at a time by walking a radix page table held in memory. The caller hands it a virtual address, an access kind (fetch, load or store) and the already decoded translation scheme: how many table levels there are, how many index bits each level uses, whether table entries are 4 or 8 bytes wide, and the physical base of the top-level table. The walker then reads one table entry per level through a single-outstanding 32-bit memory read port, working from the top level down. It ends each walk with either a physical address or an access-fault cause that matches the access kind.

A scheme with zero levels means translation is switched off: the address passes straight through with no memory traffic. Before any table read, the walker rejects addresses whose upper bits are not a sign extension of the translated range. One datapath covers schemes from two to six levels, so the same instance serves both narrow 32-bit style tables and wide 64-bit style tables. Accessed/dirty updates, permission policy and caching of translations are left to neighbouring logic.

Top module: `ptw_walker`

## Requirements
- R1: When the level count is 0, the walk ends with `paddr` equal to `req_vaddr`, no fault, and no memory request.
- R2: With `vbits = 12 + levels * idx_bits`, every address bit from XLEN-1 down to `vbits-1` must equal bit XLEN-1; otherwise the walk faults without any memory request. When `vbits-1` is at or above XLEN the check always passes.
- R3: The walk starts at level `levels-1` and steps down; at level i the index is `(vaddr >> (12 + i*idx_bits))` masked to `idx_bits` bits, and the entry address is the current table base plus index times the entry size.
- R4: A 4-byte entry is fetched with one 32-bit read. An 8-byte entry is fetched with two reads, the first at the entry address giving bits 31:0 and the second at the entry address plus 4 giving bits 63:32. At most one read is outstanding.
- R5: A read answered with `mem_rsp_err` high ends the walk with a fault.
- R6: The fault cause follows the access kind: `req_acc` 0 (fetch) gives cause 1, 1 (load) gives cause 5, 2 (store) gives cause 7.
- R7: An entry with bit 0 set is a leaf if bit 1 or bit 3 is set; a leaf gives `paddr = ((pte >> 10) << 12) | vaddr[11:0]`. A valid non-leaf entry makes `(pte >> 10) << 12` the base for the next level.
- R8: An entry with bit 0 clear, or a valid non-leaf entry found at level 0, ends the walk with a fault.
- R9: `done` is high for exactly one cycle per walk; `fault` is only high together with `done`.
- R10: A request is taken only while `busy` is low; `req_valid` during a walk is ignored and does not change the result of the walk in progress. A synchronous reset returns the walker to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | XLEN | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_levels | input | LVL_W | Number of table levels, 0 = translation off |
| req_idx_bits | input | IDX_W | Index bits per level |
| req_pte_wide | input | 1 | 1 = 8-byte entries, 0 = 4-byte entries |
| req_root | input | XLEN | Physical base of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | XLEN | Byte address of the 32-bit word read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_err | input | 1 | Read address is outside valid memory |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk failed (with done) |
| fault_cause | output | 4 | Access-fault cause (valid with fault) |
| paddr | output | XLEN | Translated physical address (valid with done, no fault) |

## Verification
The bench builds the walker with XLEN 64, up to six levels and a 4-bit index-width field, and drives both entry sizes through the same instance. This puts two-level 10-bit walks with 4-byte entries, three-, four- and six-level 9-bit walks with 8-byte entries, and a six-level scheme whose translated range is wider than XLEN all within reach. The memory model sits at a fixed window, so addresses just outside it exercise the error path, and leaf entries with a non-zero upper word show that the second read lands in bits 63:32.

// File: rtl/ptw_pkg.sv
// Package: shared constants, types and helpers of the page table walker.
// Assumes: 4 KiB pages and a page number starting at entry bit 10.
package ptw_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int PPN_SHIFT  = 10;
    localparam int WORD_W     = 32;
    localparam int PTE_W      = 2 * WORD_W;

    // Entry flag positions that the walker decodes.
    localparam int FLAG_V = 0;
    localparam int FLAG_R = 1;
    localparam int FLAG_X = 3;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_CHECK = 4'd1,
        ST_RD_LO = 4'd2,
        ST_WT_LO = 4'd3,
        ST_RD_HI = 4'd4,
        ST_WT_HI = 4'd5,
        ST_EVAL  = 4'd6,
        ST_OK    = 4'd7,
        ST_FLT   = 4'd8
    } walk_st_e;

    localparam logic [3:0] CAUSE_FETCH = 4'd1;
    localparam logic [3:0] CAUSE_LOAD  = 4'd5;
    localparam logic [3:0] CAUSE_STORE = 4'd7;

    // Map the access kind onto its access-fault cause.
    function automatic logic [3:0] cause_of(input logic [1:0] acc);
        case (acc)
            ACC_FETCH: return CAUSE_FETCH;
            ACC_STORE: return CAUSE_STORE;
            default:   return CAUSE_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
// Module: ptw_addr_gen
// Purely combinational. Checks that the upper virtual address bits are a
// sign extension of the translated range and forms the byte address of the
// table entry for the current level.
// Assumes: levels * idx_bits + PAGE_SHIFT fits an int; base is entry aligned.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LVL_W = 3,
    parameter int IDX_W = 4
) (
    input  logic [XLEN-1:0]  vaddr,
    input  logic [LVL_W-1:0] levels,
    input  logic [LVL_W-1:0] level_cur,
    input  logic [IDX_W-1:0] idx_bits,
    input  logic             pte_wide,
    input  logic [XLEN-1:0]  base,
    output logic             canon_ok,
    output logic [XLEN-1:0]  pte_addr
);

    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    int              vbits;
    int              shift;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] idx_mask;
    logic [XLEN-1:0] index;

    // Sign-extension check over the bits above the translated range.
    always_comb begin
        vbits    = PAGE_SHIFT + int'(levels) * int'(idx_bits);
        canon_ok = 1'b1;
        for (int b = 0; b < XLEN; b++) begin
            if ((b >= vbits - 1) && (vaddr[b] != vaddr[XLEN-1])) begin
                canon_ok = 1'b0;
            end
        end
    end

    // Index extraction and entry address for the level being walked.
    always_comb begin
        shift    = PAGE_SHIFT + int'(level_cur) * int'(idx_bits);
        shifted  = vaddr >> shift;
        idx_mask = (ONE << idx_bits) - ONE;
        index    = shifted & idx_mask;
        pte_addr = base + (pte_wide ? (index << 3) : (index << 2));
    end

endmodule

// File: rtl/ptw_pte_decode.sv
// Module: ptw_pte_decode
// Purely combinational. Classifies a fetched table entry as invalid, leaf
// or pointer and derives the next table base and the leaf physical address.
// Assumes: XLEN <= PTE_W; leaf address uses the 4 KiB page offset only.
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [PTE_W-1:0]      pte,
    input  logic [PAGE_SHIFT-1:0] page_off,
    output logic                  pte_valid,
    output logic                  pte_leaf,
    output logic [XLEN-1:0]       next_base,
    output logic [XLEN-1:0]       leaf_paddr
);

    logic [PTE_W-1:0] frame;

    // Flag decode: valid bit and leaf detection from read/execute flags.
    always_comb begin
        pte_valid = pte[FLAG_V];
        pte_leaf  = pte[FLAG_R] | pte[FLAG_X];
    end

    // Page frame address, shared by the pointer and the leaf outcome.
    always_comb begin
        frame      = (pte >> PPN_SHIFT) << PAGE_SHIFT;
        next_base  = frame[XLEN-1:0];
        leaf_paddr = next_base | {{(XLEN-PAGE_SHIFT){1'b0}}, page_off};
    end

endmodule

// File: rtl/ptw_ctrl.sv
// Module: ptw_ctrl
// Walk sequencer. Latches a request while idle, runs the canonical check,
// issues one or two 32-bit reads per level, evaluates each entry and ends
// with a one-cycle done pulse (with fault on failure).
// Assumes: the memory port answers every request exactly once, in order.
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LVL_W = 3,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [XLEN-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [LVL_W-1:0] req_levels,
    input  logic [IDX_W-1:0] req_idx_bits,
    input  logic             req_pte_wide,
    input  logic [XLEN-1:0]  req_root,
    // from address generator
    input  logic             canon_ok,
    input  logic [XLEN-1:0]  pte_addr,
    // from entry decoder
    input  logic             pte_valid,
    input  logic             pte_leaf,
    input  logic [XLEN-1:0]  next_base,
    input  logic [XLEN-1:0]  leaf_paddr,
    // memory response
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rsp_data,
    // latched walk context
    output logic [XLEN-1:0]  va_q,
    output logic [LVL_W-1:0] lv_q,
    output logic [LVL_W-1:0] lvl_cur_q,
    output logic [IDX_W-1:0] ib_q,
    output logic             wide_q,
    output logic [XLEN-1:0]  base_q,
    output logic [PTE_W-1:0] pte_q,
    // block outputs
    output logic             busy,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    output logic             done,
    output logic             fault,
    output logic [3:0]       fault_cause,
    output logic [XLEN-1:0]  paddr
);

    walk_st_e   st_q, st_d;
    logic [1:0] acc_q;

    // Next-state decision for the walk sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_CHECK;
            ST_CHECK: begin
                if (lv_q == '0)     st_d = ST_OK;
                else if (!canon_ok) st_d = ST_FLT;
                else                st_d = ST_RD_LO;
            end
            ST_RD_LO: st_d = ST_WT_LO;
            ST_WT_LO: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) st_d = ST_FLT;
                    else if (wide_q) st_d = ST_RD_HI;
                    else             st_d = ST_EVAL;
                end
            end
            ST_RD_HI: st_d = ST_WT_HI;
            ST_WT_HI: begin
                if (mem_rsp_valid) st_d = mem_rsp_err ? ST_FLT : ST_EVAL;
            end
            ST_EVAL: begin
                if (!pte_valid)            st_d = ST_FLT;
                else if (pte_leaf)         st_d = ST_OK;
                else if (lvl_cur_q == '0)  st_d = ST_FLT;
                else                       st_d = ST_RD_LO;
            end
            ST_OK:    st_d = ST_IDLE;
            ST_FLT:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Walk context: request capture, level stepping, entry assembly, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            acc_q     <= '0;
            lv_q      <= '0;
            ib_q      <= '0;
            wide_q    <= 1'b0;
            lvl_cur_q <= '0;
            base_q    <= '0;
            pte_q     <= '0;
            paddr     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_vaddr;
                        acc_q     <= req_acc;
                        lv_q      <= req_levels;
                        ib_q      <= req_idx_bits;
                        wide_q    <= req_pte_wide;
                        base_q    <= req_root;
                        lvl_cur_q <= req_levels - 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (lv_q == '0) paddr <= va_q;
                end
                ST_WT_LO: begin
                    if (mem_rsp_valid && !mem_rsp_err) begin
                        pte_q <= {{WORD_W{1'b0}}, mem_rsp_data};
                    end
                end
                ST_WT_HI: begin
                    if (mem_rsp_valid && !mem_rsp_err) begin
                        pte_q[PTE_W-1:WORD_W] <= mem_rsp_data;
                    end
                end
                ST_EVAL: begin
                    if (pte_valid && pte_leaf) begin
                        paddr <= leaf_paddr;
                    end else if (pte_valid && (lvl_cur_q != '0)) begin
                        base_q    <= next_base;
                        lvl_cur_q <= lvl_cur_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Port-facing outputs decoded from the state.
    always_comb begin
        busy        = (st_q != ST_IDLE);
        mem_req     = (st_q == ST_RD_LO) || (st_q == ST_RD_HI);
        mem_addr    = (st_q == ST_RD_HI) ? (pte_addr + XLEN'(4)) : pte_addr;
        done        = (st_q == ST_OK) || (st_q == ST_FLT);
        fault       = (st_q == ST_FLT);
        fault_cause = cause_of(acc_q);
    end

    // ---------------- assertions ----------------
    // R1: a walk with translation off never reaches the memory port.
    a_r1_bare_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (lv_q != '0));

    // R3: every read belongs to a level inside the scheme.
    a_r3_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (lvl_cur_q < lv_q));

    // R4: a read request is never issued back to back (one outstanding).
    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R6: a fault always carries one of the three access-fault causes.
    a_r6_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause == CAUSE_FETCH || fault_cause == CAUSE_LOAD ||
                   fault_cause == CAUSE_STORE));

    // R9: done is a single-cycle pulse and fault never stands alone.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    // R10: the captured request cannot change while a walk is running.
    a_r10_ctx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(va_q) && $stable(lv_q)));
    a_r10_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: rtl/ptw_walker.sv
// Module: ptw_walker (top)
// Sequential multi-level page table walker: sequencer plus address
// generator plus entry decoder. See doc/BRIEF.md for the port contract.
// Assumes: XLEN <= 64, LVL_W wide enough for MAX_LEVELS.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int MAX_LEVELS = 6,
    parameter int IDX_W      = 4,
    parameter int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [XLEN-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [LVL_W-1:0]  req_levels,
    input  logic [IDX_W-1:0]  req_idx_bits,
    input  logic              req_pte_wide,
    input  logic [XLEN-1:0]   req_root,
    output logic              busy,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [3:0]        fault_cause,
    output logic [XLEN-1:0]   paddr
);

    logic [XLEN-1:0]  va_q;
    logic [LVL_W-1:0] lv_q;
    logic [LVL_W-1:0] lvl_cur_q;
    logic [IDX_W-1:0] ib_q;
    logic             wide_q;
    logic [XLEN-1:0]  base_q;
    logic [PTE_W-1:0] pte_q;
    logic             canon_ok;
    logic [XLEN-1:0]  pte_addr;
    logic             pte_valid;
    logic             pte_leaf;
    logic [XLEN-1:0]  next_base;
    logic [XLEN-1:0]  leaf_paddr;

    ptw_ctrl #(.XLEN(XLEN), .LVL_W(LVL_W), .IDX_W(IDX_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_acc      (req_acc),
        .req_levels   (req_levels),
        .req_idx_bits (req_idx_bits),
        .req_pte_wide (req_pte_wide),
        .req_root     (req_root),
        .canon_ok     (canon_ok),
        .pte_addr     (pte_addr),
        .pte_valid    (pte_valid),
        .pte_leaf     (pte_leaf),
        .next_base    (next_base),
        .leaf_paddr   (leaf_paddr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err  (mem_rsp_err),
        .mem_rsp_data (mem_rsp_data),
        .va_q         (va_q),
        .lv_q         (lv_q),
        .lvl_cur_q    (lvl_cur_q),
        .ib_q         (ib_q),
        .wide_q       (wide_q),
        .base_q       (base_q),
        .pte_q        (pte_q),
        .busy         (busy),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .done         (done),
        .fault        (fault),
        .fault_cause  (fault_cause),
        .paddr        (paddr)
    );

    ptw_addr_gen #(.XLEN(XLEN), .LVL_W(LVL_W), .IDX_W(IDX_W)) addr_i (
        .vaddr    (va_q),
        .levels   (lv_q),
        .level_cur(lvl_cur_q),
        .idx_bits (ib_q),
        .pte_wide (wide_q),
        .base     (base_q),
        .canon_ok (canon_ok),
        .pte_addr (pte_addr)
    );

    ptw_pte_decode #(.XLEN(XLEN)) dec_i (
        .pte       (pte_q),
        .page_off  (va_q[PAGE_SHIFT-1:0]),
        .pte_valid (pte_valid),
        .pte_leaf  (pte_leaf),
        .next_base (next_base),
        .leaf_paddr(leaf_paddr)
    );

endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] MEM_LO     = 64'h8000_0000;
    localparam int          MEM_WORDS  = 4096;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  acc;
        logic [2:0]  lv;
        logic [3:0]  ib;
        logic        wide;
        logic [63:0] root;
        logic        exp_flt;
        logic [3:0]  exp_cause;
        logic [63:0] exp_pa;
        logic [3:0]  exp_reads;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_8060_5ABC, 2'd1, 3'd3, 4'd9,  1'b1, 64'h8000_0000, 1'b0, 4'd0, 64'h0000_0100_0000_1ABC, 4'd6},
        '{64'h0000_0000_0040_7123, 2'd0, 3'd2, 4'd10, 1'b0, 64'h8000_3000, 1'b0, 4'd0, 64'h0000_0000_00AB_C123, 4'd2},
        '{64'h0000_0040_0000_0000, 2'd2, 3'd3, 4'd9,  1'b1, 64'h8000_0000, 1'b1, 4'd7, 64'h0,                   4'd0},
        '{64'hFFFF_FFC0_0000_0000, 2'd1, 3'd3, 4'd9,  1'b1, 64'h8000_0000, 1'b1, 4'd5, 64'h0,                   4'd2},
        '{64'hDEAD_BEEF_0123_4567, 2'd0, 3'd0, 4'd9,  1'b1, 64'h8000_0000, 1'b0, 4'd0, 64'hDEAD_BEEF_0123_4567, 4'd0},
        '{64'h0000_0000_0000_1000, 2'd0, 3'd2, 4'd10, 1'b0, 64'h9000_0000, 1'b1, 4'd1, 64'h0,                   4'd1},
        '{64'h0000_0000_0080_8000, 2'd0, 3'd2, 4'd10, 1'b0, 64'h8000_3000, 1'b1, 4'd1, 64'h0,                   4'd2},
        '{64'h0000_0080_0000_0777, 2'd2, 3'd4, 4'd9,  1'b1, 64'h8000_1000, 1'b0, 4'd0, 64'h0000_0000_0000_1777, 4'd2},
        '{64'hFE00_0000_0000_0ABC, 2'd1, 3'd6, 4'd9,  1'b1, 64'h8000_3000, 1'b0, 4'd0, 64'h0000_0000_0000_3ABC, 4'd2}
    };

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [1:0]  req_acc;
    logic [2:0]  req_levels;
    logic [3:0]  req_idx_bits;
    logic        req_pte_wide;
    logic [63:0] req_root;
    logic        busy;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rsp_valid;
    logic        mem_rsp_err;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic        fault;
    logic [3:0]  fault_cause;
    logic [63:0] paddr;

    logic [31:0] mem [MEM_WORDS];
    logic [63:0] mem_off;
    int n_checks = 0;
    int n_fail   = 0;

    ptw_walker #(.XLEN(64), .MAX_LEVELS(6), .IDX_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_levels(req_levels), .req_idx_bits(req_idx_bits),
        .req_pte_wide(req_pte_wide), .req_root(req_root), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data), .done(done),
        .fault(fault), .fault_cause(fault_cause), .paddr(paddr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: one-cycle latency, error outside the window.
    assign mem_off = mem_addr - MEM_LO;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_rsp_valid <= mem_req;
            mem_rsp_err   <= 1'b1;
            mem_rsp_data  <= '0;
            if (mem_req && mem_addr >= MEM_LO && mem_addr < MEM_LO + 64'(4*MEM_WORDS)
                && mem_addr[1:0] == 2'b00) begin
                mem_rsp_err  <= 1'b0;
                mem_rsp_data <= mem[mem_off[13:2]];
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0: return "R3 R4 R7 three-level wide";
            1: return "R3 R4 R7 two-level narrow";
            2: return "R2 R6 non-canonical store";
            3: return "R2 R8 negative canonical, invalid entry";
            4: return "R1 bare pass-through";
            5: return "R5 R6 read error fetch";
            6: return "R8 non-leaf at level 0";
            7: return "R7 four-level top leaf";
            default: return "R2 R3 six-level wider than XLEN";
        endcase
    endfunction

    task automatic drive(input vec_t v);
        req_vaddr    = v.va;
        req_acc      = v.acc;
        req_levels   = v.lv;
        req_idx_bits = v.ib;
        req_pte_wide = v.wide;
        req_root     = v.root;
    endtask

    // Wait for done from the current negedge; count reads on the way.
    task automatic wait_done(output logic seen, output int reads,
                             output logic flt, output logic [3:0] cause,
                             output logic [63:0] pa);
        seen = 1'b0; reads = 0; flt = 1'b0; cause = '0; pa = '0;
        for (int c = 0; c < 200 && !seen; c++) begin
            if (mem_req) reads++;
            if (done) begin
                seen = 1'b1; flt = fault; cause = fault_cause; pa = paddr;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic run_vec(input int i);
        logic seen, flt;
        logic [3:0] cause;
        logic [63:0] pa;
        int reads;
        string t;
        vec_t v;
        v = VECS[i];
        t = tag_of(i);
        @(negedge clk);
        drive(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen, reads, flt, cause, pa);
        check(t, "done seen", 64'(seen), 64'd1);
        check(t, "fault", 64'(flt), 64'(v.exp_flt));
        if (v.exp_flt) check(t, "fault_cause (R6)", 64'(cause), 64'(v.exp_cause));
        else           check(t, "paddr", pa, v.exp_pa);
        check(t, "read count", 64'(reads), 64'(v.exp_reads));
        @(negedge clk);
        check("R9", "done single cycle", 64'(done), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic seen, flt;
        logic [3:0] cause;
        logic [63:0] pa;
        int reads;

        for (int w = 0; w < MEM_WORDS; w++) mem[w] = '0;
        mem[4]    = 32'h2000_0401;  // top table entry 2 -> table at 0x80001000
        mem[1030] = 32'h2000_0801;  // entry 3 -> table at 0x80002000
        mem[2058] = 32'h0000_040F;  // leaf, low word
        mem[2059] = 32'h0000_0040;  // leaf, high word
        mem[3073] = 32'h2000_0801;  // narrow entry 1 -> 0x80002000
        mem[2055] = 32'h002A_F003;  // narrow leaf, frame 0xABC
        mem[3074] = 32'h2000_0801;  // narrow entry 2 -> 0x80002000
        mem[2056] = 32'h0000_0001;  // valid pointer at level 0
        mem[1026] = 32'h0000_040B;  // top-level leaf, frame 1
        mem[3326] = 32'h0000_0C07;  // six-level leaf, frame 3

        rst_n = 1'b0; req_valid = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10, R9)
        check("R10", "busy after reset", 64'(busy), 64'd0);
        check("R9", "done after reset", 64'(done), 64'd0);
        check("R9", "fault after reset", 64'(fault), 64'd0);
        check("R4", "mem_req after reset", 64'(mem_req), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: request held during a walk with other fields is ignored.
        @(negedge clk);
        drive(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R10", "busy during walk", 64'(busy), 64'd1);
        drive(VECS[4]);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen, flt ? reads : reads, flt, cause, pa);
        check("R10", "ignored request: fault", 64'(flt), 64'd0);
        check("R10", "ignored request: paddr", pa, VECS[0].exp_pa);
        @(negedge clk);
        @(negedge clk);
        check("R10", "no second walk", 64'(busy), 64'd0);
        check("R9", "no extra done", 64'(done), 64'd0);

        // R10: reset in the middle of a walk returns to idle.
        drive(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "busy in reset", 64'(busy), 64'd0);
        check("R4", "mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        run_vec(1);

        summary();
        $finish;
    end

endmodule